// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits between four peripheral request lines and the transfer engine of a DMA controller. It decides which channel the engine serves next and drives one acknowledge line for that channel. Each request line passes through a two-stage synchroniser. A configuration bit sets the electrical sense of the requests, and a second bit sets the sense of the acknowledges. Configuration arrives as plain static input bits.

A mode bit selects the priority scheme. With fixed priority the lowest-numbered requesting channel wins. With rotating priority a pointer marks the channel that currently ranks highest, and the search wraps upward from that pointer. The transfer engine pulses `served` when it finishes servicing the granted channel. That pulse moves the pointer so the served channel drops to the lowest rank. While the engine holds `grant_hold` high, the current owner keeps its acknowledge. A disable bit stops any new grant from being issued.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted and on the first clock after it, no channel is granted. `ack_out` then shows every line at its inactive level: all ones when `cfg_ack_high`=0, all zeros when `cfg_ack_high`=1.
- R2: A request applied before a clock edge first shows up on `ack_out` after the third rising edge. Two of those edges are synchroniser stages and one is the grant register. After only two edges the change is not yet visible.
- R3: `cfg_req_low`=0 treats a 1 on `req_in[i]` as a request for channel i. `cfg_req_low`=1 treats a 0 as a request.
- R4: `cfg_ack_high`=1 drives the granted channel's `ack_out` bit to 1 and the others to 0. `cfg_ack_high`=0 drives the granted bit to 0 and the others to 1. The sense applies combinationally to the registered grant.
- R5: With `cfg_rotate`=0, the requesting channel with the smallest index is granted, whatever the pointer holds.
- R6: With `cfg_rotate`=1, the grant goes to the first requesting channel found by searching upward from the pointer and wrapping from 3 to 0. A `served` pulse while channel g is granted sets the pointer to (g+1) mod 4 on the next edge, which makes g the lowest-ranked channel.
- R7: After reset the pointer is 0, so in rotating mode channel 0 ranks highest.
- R8: While `grant_hold`=1 and a channel is granted, that grant stays unchanged. This holds even if its own request drops or a higher-ranked request appears.
- R9: With `grant_hold`=0 the grant is decided again on every edge, and it falls to none once no synchronised request is active.
- R10: With `cfg_disable`=1 no new grant is issued and an unheld grant is dropped. A grant held by `grant_hold` survives.
- R11: At most one `ack_out` line is at its active level at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rotate | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| cfg_req_low | input | 1 | Request sense: 0 active high, 1 active low |
| cfg_ack_high | input | 1 | Acknowledge sense: 0 active low, 1 active high |
| cfg_disable | input | 1 | 1 blocks new grants |
| req_in | input | 4 | Raw request line per channel, may be asynchronous |
| grant_hold | input | 1 | Keeps the current owner's grant while high |
| served | input | 1 | One-cycle pulse: the granted channel has been served |
| ack_out | output | 4 | Acknowledge line per channel |

## Verification
A request change made before edge k first shows on `ack_out` just after edge k+2. The bench therefore steps three falling edges after each request change before it compares, and in the latency scenario it also confirms that nothing has moved after two. Changes to `grant_hold` and `cfg_disable` act on the next edge alone, since the synchronised requests have already settled. A `served` pulse updates the pointer on the edge where it is sampled, so the new ranking appears one edge after that. The acknowledge sense is combinational, so the bench checks it at once, even during reset. All inputs are driven and all outputs sampled just after a falling edge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Next index in a ring of n positions.
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // First set bit of v, searching upward from start and wrapping within n.
  // Returns -1 when none of the n low bits is set.
  function automatic int ring_first(input logic [31:0] v, input int start, input int n);
    int c;
    for (int k = 0; k < 32; k++) begin
      if (k < n) begin
        c = (start + k) % n;
        if (v[c]) return c;
      end
    end
    return -1;
  endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_raw,
  input  logic           invert,
  output logic [NCH-1:0] req_act
);
  // Sense is applied ahead of the flops, so a reset value of zero means "no request"
  // under either sense.
  logic [NCH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= req_raw ^ {NCH{invert}};
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign req_act = stage_q[STAGES-1];

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [IW-1:0]  ptr,
  output logic           any,
  output logic [IW-1:0]  win_idx
);
  import dma_arb_pkg::*;

  // Fixed scheme: a prefix chain blocks every channel above the first requester.
  logic [NCH:0]   blocked;
  logic [NCH-1:0] fix_oh;
  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_fix
    assign fix_oh[i]    = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  logic [IW-1:0] fix_idx;
  logic [IW-1:0] rot_idx;
  int            rot_hit;

  always_comb begin
    fix_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (fix_oh[i]) fix_idx = IW'(i);
  end

  always_comb begin
    rot_hit = ring_first(32'(req), int'(ptr), NCH);
    rot_idx = IW'(rot_hit);
  end

  assign any     = |req;
  assign win_idx = rotate ? rot_idx : fix_idx;

  always_comb begin
    p_fix_onehot_r11: assert ($onehot0(fix_oh));
    if (any) begin
      p_win_requested_r5: assert (req[win_idx]);
    end
  end

endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any,
  input  logic [IW-1:0]  win_idx,
  input  logic           hold,
  input  logic           served,
  input  logic           dis,
  output logic [NCH-1:0] grant,
  output logic [IW-1:0]  ptr
);
  import dma_arb_pkg::*;

  logic [NCH-1:0] grant_q;
  logic [IW-1:0]  owner_idx;
  logic [IW-1:0]  ptr_q;

  // Named internal events.
  logic owner_vld, ev_keep, ev_new, ev_rotate;
  assign owner_vld = |grant_q;
  assign ev_keep   = owner_vld & hold;
  assign ev_new    = ~ev_keep & ~dis & any;
  assign ev_rotate = served & owner_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q   <= '0;
      owner_idx <= '0;
    end else if (ev_keep) begin
      grant_q   <= grant_q;
    end else if (ev_new) begin
      grant_q   <= NCH'(1) << win_idx;
      owner_idx <= win_idx;
    end else begin
      grant_q   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (ev_rotate) ptr_q <= IW'(ring_next(int'(owner_idx), NCH));
  end

  assign grant = grant_q;
  assign ptr   = ptr_q;

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  p_hold_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_vld && hold) |=> $stable(grant_q));

  p_disable_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !(owner_vld && hold)) |=> (grant_q == '0));

  p_rotate_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (served && owner_vld) |=> (int'(ptr_q) == (int'($past(owner_idx)) + 1) % NCH));

  p_owner_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    owner_vld |-> grant_q[owner_idx]);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_rotate,
  input  logic           cfg_req_low,
  input  logic           cfg_ack_high,
  input  logic           cfg_disable,
  input  logic [NCH-1:0] req_in,
  input  logic           grant_hold,
  input  logic           served,
  output logic [NCH-1:0] ack_out
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] req_act;
  logic           req_any;
  logic [IW-1:0]  win_idx;
  logic [IW-1:0]  ptr;
  logic [NCH-1:0] grant;

  dma_req_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_raw (req_in),
    .invert  (cfg_req_low),
    .req_act (req_act)
  );

  dma_prio_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .req     (req_act),
    .rotate  (cfg_rotate),
    .ptr     (ptr),
    .any     (req_any),
    .win_idx (win_idx)
  );

  dma_grant_ctrl #(.NCH(NCH), .IW(IW)) u_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .any     (req_any),
    .win_idx (win_idx),
    .hold    (grant_hold),
    .served  (served),
    .dis     (cfg_disable),
    .grant   (grant),
    .ptr     (ptr)
  );

  assign ack_out = grant ^ {NCH{~cfg_ack_high}};

  p_ack_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_ack_high ? ack_out : ~ack_out) <= 1);

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_rotate = 1'b0, cfg_req_low = 1'b0, cfg_ack_high = 1'b0, cfg_disable = 1'b0;
  logic [3:0] req_in = 4'h0;
  logic       grant_hold = 1'b0, served = 1'b0;
  logic [3:0] ack_out;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rotate(cfg_rotate), .cfg_req_low(cfg_req_low),
    .cfg_ack_high(cfg_ack_high), .cfg_disable(cfg_disable), .req_in(req_in),
    .grant_hold(grant_hold), .served(served), .ack_out(ack_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exp_grant is the one-hot channel expected (0 = none); port sense per R4.
  task automatic chk(input logic [3:0] exp_grant, input string tag);
    logic [3:0] exp_port;
    logic [3:0] active;
    exp_port = cfg_ack_high ? exp_grant : ~exp_grant;
    vectors++;
    if (ack_out !== exp_port) begin
      miscompares++;
      $display("FAIL %s: ack_out=%b expected=%b", tag, ack_out, exp_port);
    end
    active = cfg_ack_high ? ack_out : ~ack_out;
    vectors++;
    if ($countones(active) > 1) begin
      miscompares++;
      $display("FAIL R11: active acks=%b expected at most one", active);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    grant_hold = 1'b0; served = 1'b0; cfg_disable = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    cfg_ack_high = 1'b0; req_in = 4'hF;
    rst_n = 1'b0; step(2);
    chk(4'b0000, "R1 in reset, active-low acks");
    cfg_ack_high = 1'b1; #1;
    chk(4'b0000, "R4 in reset, active-high acks");
    vectors++;
    if (ack_out !== 4'b0000) begin
      miscompares++;
      $display("FAIL R4: ack_out=%b expected=0000", ack_out);
    end
    rst_n = 1'b1; step(1);
    chk(4'b0000, "R1 first clock after reset");
    req_in = 4'h0; cfg_ack_high = 1'b0;
  endtask

  task automatic t_latency();
    do_reset();
    req_in = 4'b0100;
    step(2);
    chk(4'b0000, "R2 not yet after two edges");
    step(1);
    chk(4'b0100, "R2 grant after three edges");
    cfg_ack_high = 1'b1; #1;
    chk(4'b0100, "R4 active-high grant");
    vectors++;
    if (ack_out !== 4'b0100) begin
      miscompares++;
      $display("FAIL R4: ack_out=%b expected=0100", ack_out);
    end
    cfg_ack_high = 1'b0;
    req_in = 4'h0; step(3);
  endtask

  task automatic t_fixed();
    do_reset(); cfg_rotate = 1'b0;
    req_in = 4'b1010; step(3); chk(4'b0010, "R5 fixed 1010");
    req_in = 4'b1100; step(3); chk(4'b0100, "R5 fixed 1100");
    req_in = 4'b1111; step(3); chk(4'b0001, "R5 fixed 1111");
    req_in = 4'h0; step(3); chk(4'b0000, "R9 no requests");
  endtask

  task automatic t_polarity();
    cfg_req_low = 1'b1; req_in = 4'hF;
    do_reset(); step(3);
    chk(4'b0000, "R3 active-low idle");
    req_in = 4'b0111; step(3); chk(4'b1000, "R3 active-low ch3");
    req_in = 4'b1001; step(3); chk(4'b0010, "R3 active-low ch1,ch2");
    cfg_req_low = 1'b0; req_in = 4'h0; step(3);
  endtask

  task automatic pulse_served(input logic [3:0] cur, input logic [3:0] nxt, input string tag);
    served = 1'b1; step(1); served = 1'b0;
    chk(cur, {tag, " same edge"});
    step(1);
    chk(nxt, tag);
  endtask

  task automatic t_rotate();
    cfg_rotate = 1'b1; do_reset();
    req_in = 4'b1111; step(3);
    chk(4'b0001, "R7 ptr 0 after reset");
    pulse_served(4'b0001, 4'b0010, "R6 rotate to ch1");
    pulse_served(4'b0010, 4'b0100, "R6 rotate to ch2");
    pulse_served(4'b0100, 4'b1000, "R6 rotate to ch3");
    pulse_served(4'b1000, 4'b0001, "R6 wrap to ch0");
    pulse_served(4'b0001, 4'b0010, "R6 rotate to ch1 again");
    req_in = 4'b0101; step(3); chk(4'b0100, "R6 ptr1 picks ch2");
    req_in = 4'b0001; step(3); chk(4'b0001, "R6 ptr1 wraps to ch0");
    cfg_rotate = 1'b0; req_in = 4'b1100; step(1); chk(4'b0001, "R5 fixed ignores ptr, pending");
    step(2); chk(4'b0100, "R5 fixed ignores ptr");
    req_in = 4'h0; step(3);
  endtask

  task automatic t_hold();
    cfg_rotate = 1'b0; do_reset();
    req_in = 4'b1000; step(3); chk(4'b1000, "R5 sole ch3");
    grant_hold = 1'b1; req_in = 4'b1111; step(4);
    chk(4'b1000, "R8 hold vs higher priority");
    req_in = 4'b0111; step(4);
    chk(4'b1000, "R8 hold after own request drops");
    grant_hold = 1'b0; step(1);
    chk(4'b0001, "R9 release re-arbitrates");
    req_in = 4'h0; step(2);
    chk(4'b0001, "R9 stale sync still ch0");
    step(1);
    chk(4'b0000, "R9 drops with no requests");
  endtask

  task automatic t_disable();
    do_reset();
    cfg_disable = 1'b1; req_in = 4'b0010; step(5);
    chk(4'b0000, "R10 disabled no grant");
    cfg_disable = 1'b0; step(1);
    chk(4'b0010, "R10 enabled grant");
    grant_hold = 1'b1; cfg_disable = 1'b1; step(3);
    chk(4'b0010, "R10 held grant survives disable");
    grant_hold = 1'b0; step(1);
    chk(4'b0000, "R10 unheld grant dropped");
    cfg_disable = 1'b0; step(1);
    chk(4'b0010, "R10 grant resumes");
    req_in = 4'h0; step(3);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_fixed();
    t_polarity();
    t_rotate();
    t_hold();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule